// File: doc/BRIEF.md
# Tagged Register File with Result Forwarding

This block holds the architectural integer registers of an out-of-order core that renames through producer tags. Each of the 32 entries keeps a 32-bit value and a 9-bit tag. A nonzero tag names the in-flight instruction that will deliver the value. A zero tag means the value is ready. When the issue stage dispatches an instruction, it writes the new producer's tag into the destination entry. The value itself arrives later, on the shared result broadcast. Every entry whose stored tag equals the broadcast tag takes the value and becomes ready.

Two combinational read ports give the issue bus a value/tag pair for each source operand. If a broadcast in the current cycle carries the tag that a read entry is waiting for, the port returns the broadcast value with a zero tag. Without this, the operand would wait for a result that has already gone past. Entry 0 is hard-wired to a ready zero. A separate link path loads entry 31 with a return address when a jump-and-link issues.

The result broadcast is a pure stream with no back-pressure. It has a valid bit and no ready, because the file accepts every broadcast in the cycle it appears. The tag write and the link load are plain control strobes.

Top module: `tagged_regfile`

## Requirements
- R1: After reset, every entry reads value 0 with tag 0 on both ports.
- R2: A tag write (`iss_we` high) sets the addressed entry's tag to `iss_tag` at the next edge and leaves its value unchanged.
- R3: A valid broadcast whose tag equals an entry's nonzero stored tag loads `res_data` into that entry and clears its tag to 0 at the next edge.
- R4: A broadcast with `res_valid` low, a broadcast whose tag matches no stored tag, and a broadcast with tag 0 change no entry.
- R5: Entry 0 always reads value 0 with tag 0. Tag writes addressed to it are ignored.
- R6: When a port reads an entry whose nonzero tag equals a valid broadcast tag in the same cycle, the port returns `res_data` with tag 0 instead of the stored pair.
- R7: When a tag write and a matching broadcast hit the same entry in one cycle, the entry takes the broadcast value and keeps the newly written tag.
- R8: With `lnk_en` high, entry 31 is loaded with `lnk_pc` and its tag is cleared at the next edge, unless a tag write to entry 31 happens in the same cycle, in which case the new tag is kept.
- R9: Every entry that holds the broadcast tag updates in the same cycle, and the two ports forward independently, including when both read the same entry.
- R10: When the link load and a matching broadcast hit entry 31 together, the link value is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_we | input | 1 | Tag write strobe from issue |
| iss_dst | input | 5 | Entry whose tag is written |
| iss_tag | input | 9 | Producer tag to store |
| res_valid | input | 1 | Result broadcast valid |
| res_tag | input | 9 | Tag of the broadcast result |
| res_data | input | 32 | Broadcast result value |
| lnk_en | input | 1 | Load return address into entry 31 |
| lnk_pc | input | 32 | Return address value |
| rda_addr | input | 5 | Read port A entry |
| rda_data | output | 32 | Read port A value |
| rda_tag | output | 9 | Read port A tag |
| rdb_addr | input | 5 | Read port B entry |
| rdb_data | output | 32 | Read port B value |
| rdb_tag | output | 9 | Read port B tag |

## Verification
The bench reads an entry in the very cycle its producer broadcasts. A file without forwarding would return a stale zero value with a live tag there, and the consumer would wait forever. It writes a new tag and broadcasts the old one into the same entry. A design that lets the clear win would mark the entry ready, so later consumers would read the older result. It also sends broadcasts that are not valid, that carry no match, or that carry tag 0. A sloppy comparison would corrupt entries, entry 0 above all. Finally, it collides the link load with a broadcast and with a tag write on entry 31. A wrong priority would store the broadcast value or drop the new tag.

// File: rtl/rf_pkg.sv
package rf_pkg;
  // Source selected for an entry's value at the next edge.
  typedef enum logic [1:0] {
    SRC_HOLD = 2'd0,
    SRC_RES  = 2'd1,
    SRC_LNK  = 2'd2
  } val_src_e;
endpackage

// File: rtl/rf_entry.sv
module rf_entry
  import rf_pkg::*;
#(
  parameter int IDX   = 1,
  parameter int NREG  = 32,
  parameter int DW    = 32,
  parameter int TW    = 9,
  parameter bit LINK  = 1'b0,
  localparam int AW   = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          iss_we,
  input  logic [AW-1:0] iss_dst,
  input  logic [TW-1:0] iss_tag,
  input  logic          res_valid,
  input  logic [TW-1:0] res_tag,
  input  logic [DW-1:0] res_data,
  input  logic          lnk_en,
  input  logic [DW-1:0] lnk_pc,
  output logic [DW-1:0] val_q,
  output logic [TW-1:0] tag_q
);
  localparam logic [AW-1:0] MY_ADDR = IDX[AW-1:0];

  logic     hit, wr_here, lnk_here;
  val_src_e src;

  assign hit      = res_valid && (tag_q != '0) && (res_tag == tag_q);
  assign wr_here  = iss_we && (iss_dst == MY_ADDR);
  assign lnk_here = LINK && lnk_en;

  always_comb begin
    if (lnk_here)  src = SRC_LNK;
    else if (hit)  src = SRC_RES;
    else           src = SRC_HOLD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q <= '0;
      tag_q <= '0;
    end else begin
      case (src)
        SRC_LNK: val_q <= lnk_pc;
        SRC_RES: val_q <= res_data;
        default: val_q <= val_q;
      endcase
      if (wr_here)              tag_q <= iss_tag;
      else if (hit || lnk_here) tag_q <= '0;
    end
  end

  // R2: a written tag appears at the next edge
  p_tag_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_here |=> tag_q == $past(iss_tag));
  // R3: matching broadcast delivers its value (link absent)
  p_res_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !lnk_here) |=> val_q == $past(res_data));
  // R3: matching broadcast without a new tag leaves the entry ready
  p_res_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !wr_here) |=> tag_q == '0);
  // R4: no event, no change
  p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit && !wr_here && !lnk_here) |=> ($stable(val_q) && $stable(tag_q)));
  // R8 / R10: link load value has priority
  p_link_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    lnk_here |=> val_q == $past(lnk_pc));
endmodule

// File: rtl/rf_read_port.sv
module rf_read_port #(
  parameter int NREG = 32,
  parameter int DW   = 32,
  parameter int TW   = 9,
  localparam int AW  = $clog2(NREG)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [AW-1:0]            addr,
  input  logic [NREG-1:0][DW-1:0]  val_all,
  input  logic [NREG-1:0][TW-1:0]  tag_all,
  input  logic                     res_valid,
  input  logic [TW-1:0]            res_tag,
  input  logic [DW-1:0]            res_data,
  output logic [DW-1:0]            out_data,
  output logic [TW-1:0]            out_tag
);
  logic [DW-1:0] sel_val;
  logic [TW-1:0] sel_tag;
  logic          fwd;

  assign sel_val = val_all[addr];
  assign sel_tag = tag_all[addr];
  assign fwd     = res_valid && (sel_tag != '0) && (sel_tag == res_tag);

  always_comb begin
    if (fwd) begin
      out_data = res_data;
      out_tag  = '0;
    end else begin
      out_data = sel_val;
      out_tag  = sel_tag;
    end
  end

  // R5: entry 0 is a ready zero at the port
  p_zero_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == '0) |-> (out_data == '0 && out_tag == '0));
  // R6: a port never shows a tag that is being broadcast this cycle
  p_no_stale_tag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_tag != '0) |-> (out_tag != res_tag));
endmodule

// File: rtl/tagged_regfile.sv
module tagged_regfile #(
  parameter int NREG = 32,
  parameter int DW   = 32,
  parameter int TW   = 9,
  parameter int NRD  = 2,
  localparam int AW  = $clog2(NREG),
  localparam int LNK_IDX = NREG - 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          iss_we,
  input  logic [AW-1:0] iss_dst,
  input  logic [TW-1:0] iss_tag,
  input  logic          res_valid,
  input  logic [TW-1:0] res_tag,
  input  logic [DW-1:0] res_data,
  input  logic          lnk_en,
  input  logic [DW-1:0] lnk_pc,
  input  logic [AW-1:0] rda_addr,
  output logic [DW-1:0] rda_data,
  output logic [TW-1:0] rda_tag,
  input  logic [AW-1:0] rdb_addr,
  output logic [DW-1:0] rdb_data,
  output logic [TW-1:0] rdb_tag
);
  logic [NREG-1:0][DW-1:0] val_all;
  logic [NREG-1:0][TW-1:0] tag_all;
  logic [NRD-1:0][AW-1:0]  rd_addr;
  logic [NRD-1:0][DW-1:0]  rd_data;
  logic [NRD-1:0][TW-1:0]  rd_tag;

  for (genvar i = 0; i < NREG; i++) begin : g_ent
    if (i == 0) begin : g_zero
      assign val_all[i] = '0;
      assign tag_all[i] = '0;
    end else begin : g_live
      rf_entry #(
        .IDX(i), .NREG(NREG), .DW(DW), .TW(TW), .LINK(i == LNK_IDX)
      ) u_ent (
        .clk(clk), .rst_n(rst_n),
        .iss_we(iss_we), .iss_dst(iss_dst), .iss_tag(iss_tag),
        .res_valid(res_valid), .res_tag(res_tag), .res_data(res_data),
        .lnk_en(lnk_en), .lnk_pc(lnk_pc),
        .val_q(val_all[i]), .tag_q(tag_all[i])
      );
    end
  end

  assign rd_addr[0] = rda_addr;
  assign rd_addr[1] = rdb_addr;

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    rf_read_port #(.NREG(NREG), .DW(DW), .TW(TW)) u_rd (
      .clk(clk), .rst_n(rst_n),
      .addr(rd_addr[p]), .val_all(val_all), .tag_all(tag_all),
      .res_valid(res_valid), .res_tag(res_tag), .res_data(res_data),
      .out_data(rd_data[p]), .out_tag(rd_tag[p])
    );
  end

  assign rda_data = rd_data[0];
  assign rda_tag  = rd_tag[0];
  assign rdb_data = rd_data[1];
  assign rdb_tag  = rd_tag[1];

  // R9: two ports on one entry agree
  p_ports_agree_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rda_addr == rdb_addr) |-> (rda_data == rdb_data && rda_tag == rdb_tag));
  // R5: a tag write to entry 0 leaves it a ready zero
  p_zero_ignore_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_we && iss_dst == '0) |=> (val_all[0] == '0 && tag_all[0] == '0));
endmodule

// File: tb/test_tagged_regfile.sv
module test_tagged_regfile;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        iss_we = 1'b0;
  logic [4:0]  iss_dst = '0;
  logic [8:0]  iss_tag = '0;
  logic        res_valid = 1'b0;
  logic [8:0]  res_tag = '0;
  logic [31:0] res_data = '0;
  logic        lnk_en = 1'b0;
  logic [31:0] lnk_pc = '0;
  logic [4:0]  rda_addr = '0, rdb_addr = '0;
  logic [31:0] rda_data, rdb_data;
  logic [8:0]  rda_tag, rdb_tag;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  tagged_regfile i_tagged_regfile (
    .clk(clk), .rst_n(rst_n),
    .iss_we(iss_we), .iss_dst(iss_dst), .iss_tag(iss_tag),
    .res_valid(res_valid), .res_tag(res_tag), .res_data(res_data),
    .lnk_en(lnk_en), .lnk_pc(lnk_pc),
    .rda_addr(rda_addr), .rda_data(rda_data), .rda_tag(rda_tag),
    .rdb_addr(rdb_addr), .rdb_data(rdb_data), .rdb_tag(rdb_tag)
  );

  typedef struct packed {
    logic [7:0]  req;
    logic        we;  logic [4:0] dst; logic [8:0] tg;
    logic        rv;  logic [8:0] rt;  logic [31:0] rd;
    logic        le;  logic [31:0] pc;
    logic [4:0]  a;   logic [4:0] b;
    logic [31:0] ea;  logic [8:0] eta;
    logic [31:0] eb;  logic [8:0] etb;
  } vec_t;

  localparam int NV = 24;
  // Reads are checked in the same cycle as the stimulus; writes show in the next row.
  localparam vec_t VEC [NV] = '{
    // R1 reset state
    '{8'd1, 1'b0,5'd0,9'h0,   1'b0,9'h0,32'h0,          1'b0,32'h0,    5'd5,5'd31, 32'h0,9'h0, 32'h0,9'h0},
    // R2 write tag 011 to r5
    '{8'd2, 1'b1,5'd5,9'h011, 1'b0,9'h0,32'h0,          1'b0,32'h0,    5'd5,5'd0,  32'h0,9'h0, 32'h0,9'h0},
    // R2 write tag 022 to r7; r5 shows tag, value unchanged
    '{8'd2, 1'b1,5'd7,9'h022, 1'b0,9'h0,32'h0,          1'b0,32'h0,    5'd5,5'd7,  32'h0,9'h011, 32'h0,9'h0},
    // R4 broadcast with unmatched tag
    '{8'd4, 1'b0,5'd0,9'h0,   1'b1,9'h033,32'hAAAA0000, 1'b0,32'h0,    5'd5,5'd7,  32'h0,9'h011, 32'h0,9'h022},
    // R4 matching tag but not valid
    '{8'd4, 1'b0,5'd0,9'h0,   1'b0,9'h011,32'h0000BEEF, 1'b0,32'h0,    5'd5,5'd7,  32'h0,9'h011, 32'h0,9'h022},
    // R4 nothing changed
    '{8'd4, 1'b0,5'd0,9'h0,   1'b0,9'h0,32'h0,          1'b0,32'h0,    5'd5,5'd7,  32'h0,9'h011, 32'h0,9'h022},
    // R6 forward to port A while r5 is being written
    '{8'd6, 1'b0,5'd0,9'h0,   1'b1,9'h011,32'h12345678, 1'b0,32'h0,    5'd5,5'd7,  32'h12345678,9'h0, 32'h0,9'h022},
    // R3 r5 now holds value, tag cleared
    '{8'd3, 1'b0,5'd0,9'h0,   1'b0,9'h0,32'h0,          1'b0,32'h0,    5'd5,5'd7,  32'h12345678,9'h0, 32'h0,9'h022},
    // R5 tag write to r0
    '{8'd5, 1'b1,5'd0,9'h055, 1'b0,9'h0,32'h0,          1'b0,32'h0,    5'd0,5'd5,  32'h0,9'h0, 32'h12345678,9'h0},
    // R5 r0 unchanged; R4 zero-tag broadcast
    '{8'd5, 1'b0,5'd0,9'h0,   1'b1,9'h000,32'hFFFFFFFF, 1'b0,32'h0,    5'd0,5'd5,  32'h0,9'h0, 32'h12345678,9'h0},
    // R4 zero-tag broadcast touched nothing
    '{8'd4, 1'b0,5'd0,9'h0,   1'b0,9'h0,32'h0,          1'b0,32'h0,    5'd0,5'd5,  32'h0,9'h0, 32'h12345678,9'h0},
    // R7 new tag on r7 plus broadcast of old tag; R9 both ports forward
    '{8'd9, 1'b1,5'd7,9'h044, 1'b1,9'h022,32'hCAFE0001, 1'b0,32'h0,    5'd7,5'd7,  32'hCAFE0001,9'h0, 32'hCAFE0001,9'h0},
    // R7 value taken, new tag kept
    '{8'd7, 1'b0,5'd0,9'h0,   1'b0,9'h0,32'h0,          1'b0,32'h0,    5'd7,5'd5,  32'hCAFE0001,9'h044, 32'h12345678,9'h0},
    // R8 link load
    '{8'd8, 1'b0,5'd0,9'h0,   1'b0,9'h0,32'h0,          1'b1,32'h00001008, 5'd31,5'd5, 32'h0,9'h0, 32'h12345678,9'h0},
    // R8 r31 holds return address
    '{8'd8, 1'b0,5'd0,9'h0,   1'b0,9'h0,32'h0,          1'b0,32'h0,    5'd31,5'd30, 32'h00001008,9'h0, 32'h0,9'h0},
    // R2 tag 066 on r31
    '{8'd2, 1'b1,5'd31,9'h066,1'b0,9'h0,32'h0,          1'b0,32'h0,    5'd31,5'd30, 32'h00001008,9'h0, 32'h0,9'h0},
    // R10 link and matching broadcast together; ports forward
    '{8'd10,1'b0,5'd0,9'h0,   1'b1,9'h066,32'h0000DEAD, 1'b1,32'h00002000, 5'd31,5'd31, 32'h0000DEAD,9'h0, 32'h0000DEAD,9'h0},
    // R10 link value stored
    '{8'd10,1'b0,5'd0,9'h0,   1'b0,9'h0,32'h0,          1'b0,32'h0,    5'd31,5'd7, 32'h00002000,9'h0, 32'hCAFE0001,9'h044},
    // R9 tag 088 to r10
    '{8'd9, 1'b1,5'd10,9'h088,1'b0,9'h0,32'h0,          1'b0,32'h0,    5'd10,5'd11, 32'h0,9'h0, 32'h0,9'h0},
    // R9 tag 088 to r11
    '{8'd9, 1'b1,5'd11,9'h088,1'b0,9'h0,32'h0,          1'b0,32'h0,    5'd10,5'd11, 32'h0,9'h088, 32'h0,9'h0},
    // R9 one broadcast, two waiting entries
    '{8'd9, 1'b0,5'd0,9'h0,   1'b1,9'h088,32'h55555555, 1'b0,32'h0,    5'd10,5'd11, 32'h55555555,9'h0, 32'h55555555,9'h0},
    // R9 both updated
    '{8'd9, 1'b0,5'd0,9'h0,   1'b0,9'h0,32'h0,          1'b0,32'h0,    5'd10,5'd11, 32'h55555555,9'h0, 32'h55555555,9'h0},
    // R8 tag write and link on r31 together
    '{8'd8, 1'b1,5'd31,9'h077,1'b0,9'h0,32'h0,          1'b1,32'h00003000, 5'd31,5'd7, 32'h00002000,9'h0, 32'hCAFE0001,9'h044},
    // R8 link value with kept tag
    '{8'd8, 1'b0,5'd0,9'h0,   1'b0,9'h0,32'h0,          1'b0,32'h0,    5'd31,5'd0, 32'h00003000,9'h077, 32'h0,9'h0}
  };

  task automatic chk(input int req, input string what,
                     input logic [31:0] ad, input logic [8:0] at,
                     input logic [31:0] ed, input logic [8:0] et);
    checks++;
    if (ad !== ed || at !== et) begin
      failures++;
      $display("FAIL R%0d %s: got %h/%h expected %h/%h", req, what, ad, at, ed, et);
    end
  endtask

  task automatic idle_in();
    iss_we = 0; res_valid = 0; lnk_en = 0;
    iss_dst = '0; iss_tag = '0; res_tag = '0; res_data = '0; lnk_pc = '0;
  endtask

  initial begin : watchdog
    #400000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      iss_we = VEC[k].we; iss_dst = VEC[k].dst; iss_tag = VEC[k].tg;
      res_valid = VEC[k].rv; res_tag = VEC[k].rt; res_data = VEC[k].rd;
      lnk_en = VEC[k].le; lnk_pc = VEC[k].pc;
      rda_addr = VEC[k].a; rdb_addr = VEC[k].b;
      #1;
      chk(int'(VEC[k].req), $sformatf("row %0d port A", k), rda_data, rda_tag, VEC[k].ea, VEC[k].eta);
      chk(int'(VEC[k].req), $sformatf("row %0d port B", k), rdb_data, rdb_tag, VEC[k].eb, VEC[k].etb);
    end
    // R1 directed: mid-run reset clears loaded entries
    @(negedge clk);
    idle_in();
    rst_n = 1'b0;
    #1;
    rda_addr = 5'd31; rdb_addr = 5'd7;
    #1;
    chk(1, "reset r31", rda_data, rda_tag, 32'h0, 9'h0);
    chk(1, "reset r7", rdb_data, rdb_tag, 32'h0, 9'h0);
    @(negedge clk);
    rst_n = 1'b1;
    rda_addr = 5'd10; rdb_addr = 5'd5;
    #1;
    chk(1, "reset r10", rda_data, rda_tag, 32'h0, 9'h0);
    chk(1, "reset r5", rdb_data, rdb_tag, 32'h0, 9'h0);
    // R6 directed: forward on port B only, port A unaffected
    @(negedge clk);
    iss_we = 1; iss_dst = 5'd3; iss_tag = 9'h101;
    @(negedge clk);
    idle_in();
    res_valid = 1; res_tag = 9'h101; res_data = 32'h0BADF00D;
    rda_addr = 5'd4; rdb_addr = 5'd3;
    #1;
    chk(6, "fwd port B", rdb_data, rdb_tag, 32'h0BADF00D, 9'h0);
    chk(6, "other entry port A", rda_data, rda_tag, 32'h0, 9'h0);
    @(negedge clk);
    idle_in();
    #1;
    chk(3, "r3 after broadcast", rdb_data, rdb_tag, 32'h0BADF00D, 9'h0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule